// File: doc/BRIEF.md
# Protected Key Slot Register Bank

This block keeps a bank of 64 key slots. Each slot holds 256 bits of key material and a 32-bit protection word. Software never writes a slot directly. It first loads eight 32-bit staging registers. It then writes a slot number to a trigger register, and the whole staged value moves into that slot in a single commit. A commit succeeds only when the target slot exists and carries its direct-write permission. The first successful commit also turns the slot's enable flag on.

Protection words start from a parameter table at reset. After that, one register can only remove permissions. The upper half of each word mixes clearable permission flags with fixed flags for master status and group membership, and a clear never touches the fixed flags. A second register lets software pick a slot and read its protection word back one clock later. A key read port lets the secure processor fetch a slot's key. The key comes back as zero unless the slot is enabled and still allows keyring reads.

Top module: `kslot_bank`

## Requirements
- R1: After reset, every staging word and the query result read as zero. Every slot reads zero on the key port, with `key_usable` low.
- R2: A write to word address k in 0..7 stores the data in staging word k. Reading word address k returns the stored value, and the value stays the same until the next write to k.
- R3: A write to word address 8 with slot number s in bits 15:0 copies staging word k into key bits 32k+31:32k of slot s. It also sets protection bit 1 (enabled). Both take effect at the clock edge of the write. This happens only when slot s is below 64 and its protection word has bit 0 (exists) and bit 27 (direct write allowed) set.
- R4: A commit to a slot that is 64 or above, that is absent, or that lacks bit 27 changes neither the slot's key nor its protection word.
- R5: A write to word address 9 with slot s in bits 15:0 and mask m in bits 31:16 clears protection bits 16..20 and 26..31 of slot s wherever m has a one. Bits 21..25 (master, groups 0 to 3) and bits 0..15 never change.
- R6: A write to word address 10 with slot s in bits 15:0 loads slot s's protection word into the result register at that clock edge. The result is zero for s of 64 or above. Reading word address 11 returns the result. The result holds until the next such write, even if the protection word changes in the meantime.
- R7: `key_data` shows the key of slot `key_sel` only when that slot's protection bit 1 and bit 28 (keyring read allowed) are both set. Otherwise it is all zeros. `key_usable` equals bit 1.
- R8: Reset protection table:
  - Slots 56..63 are absent, with a word of 0.
  - Every other slot starts at 0x1C1F0001.
  - Slots 0..7 also set bit 22, and slots 8..15 also set bit 23.
  - Slot 16 also sets bits 21 and 22.
  - Slots 40..47 have bit 27 cleared.
- R9: Reads of word addresses 8, 9, 10 and 12..15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Word address of the write |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 4 | Word address of the read |
| bus_rdata | output | 32 | Read data, combinational from `bus_raddr` |
| key_sel | input | 6 | Slot picked for the key read port |
| key_data | output | 256 | Key of the picked slot, or zero when not readable |
| key_usable | output | 1 | Enable flag of the picked slot |

## Verification
The bench targets the cases where a permission gate can leak:
- **Commit to a blocked slot.** Commits go to slots without the direct-write flag, to absent slots and to out-of-range numbers whose upper bits are set. A design that dropped the gate, or compared only the low index bits, would enable such a slot or overwrite its key.
- **Clear with a full mask.** Full-mask clears hit slots with master and group flags. A wrong mask constant would wipe those fixed bits or the exists/enable bits.
- **Read permission removed after commit.** Clearing only the keyring-read flag on a committed slot must zero `key_data` while `key_usable` stays high.
- **Stale query result.** The query result is read after later clears of the same slot. An unregistered result would show the new word instead of holding the old one.

// File: rtl/kslot_pkg.sv
package kslot_pkg;

  localparam int DEF_SLOTS = 64;
  localparam int WORD_W    = 32;
  localparam int WORDS     = 8;
  localparam int KEY_W     = WORDS * WORD_W;
  localparam int AW        = 4;

  localparam int PB_EXIST  = 0;
  localparam int PB_EN     = 1;
  localparam int PB_SETKR  = 27;
  localparam int PB_GETKR  = 28;

  // bits a clear request may remove; 21..25 and the low half are fixed
  localparam logic [31:0] CLEARABLE = 32'hFC1F_0000;

  localparam logic [AW-1:0] RA_COMMIT = 4'd8;
  localparam logic [AW-1:0] RA_CLEAR  = 4'd9;
  localparam logic [AW-1:0] RA_QUERY  = 4'd10;
  localparam logic [AW-1:0] RA_RESULT = 4'd11;

  function automatic logic [DEF_SLOTS-1:0][31:0] default_prot();
    logic [DEF_SLOTS-1:0][31:0] t;
    for (int i = 0; i < DEF_SLOTS; i++) begin
      if (i >= 56) begin
        t[i] = '0;
      end else begin
        t[i] = 32'h1C1F_0001;
        if (i < 8)       t[i][22] = 1'b1;
        else if (i < 16) t[i][23] = 1'b1;
        if (i == 16) begin
          t[i][21] = 1'b1;
          t[i][22] = 1'b1;
        end
        if (i >= 40 && i < 48) t[i][PB_SETKR] = 1'b0;
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/kslot_regif.sv
module kslot_regif
  import kslot_pkg::*;
#(
  parameter int NWORDS = WORDS,
  parameter int DW     = WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [DW-1:0]        wdata,
  input  logic [AW-1:0]        raddr,
  input  logic [31:0]          qres,
  output logic [NWORDS*DW-1:0] stage_flat,
  output logic                 cmd_commit,
  output logic                 cmd_clear,
  output logic                 cmd_query,
  output logic [15:0]          cmd_slot,
  output logic [15:0]          cmd_mask,
  output logic [DW-1:0]        rdata
);

  logic [DW-1:0] stage_q [NWORDS];
  logic [DW-1:0] stage_d [NWORDS];

  always_comb begin
    for (int w = 0; w < NWORDS; w++) begin
      stage_d[w] = (we && waddr == AW'(w)) ? wdata : stage_q[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORDS; w++) stage_q[w] <= '0;
    end else begin
      for (int w = 0; w < NWORDS; w++) stage_q[w] <= stage_d[w];
    end
  end

  genvar gw;
  generate
    for (gw = 0; gw < NWORDS; gw++) begin : g_flat
      assign stage_flat[gw*DW +: DW] = stage_q[gw];

      assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && waddr == AW'(gw)) |=> $stable(stage_q[gw]));
    end
  endgenerate

  assign cmd_commit = we && (waddr == RA_COMMIT);
  assign cmd_clear  = we && (waddr == RA_CLEAR);
  assign cmd_query  = we && (waddr == RA_QUERY);
  assign cmd_slot   = wdata[15:0];
  assign cmd_mask   = wdata[31:16];

  always_comb begin
    rdata = '0;
    if (raddr < AW'(NWORDS))   rdata = stage_q[raddr[$clog2(NWORDS)-1:0]];
    else if (raddr == RA_RESULT) rdata = qres;
  end

endmodule

// File: rtl/kslot_prot.sv
module kslot_prot
  import kslot_pkg::*;
#(
  parameter int NUM_SLOTS = DEF_SLOTS,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter logic [NUM_SLOTS-1:0][31:0] INIT_PROT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_commit,
  input  logic             cmd_clear,
  input  logic             cmd_query,
  input  logic [15:0]      cmd_slot,
  input  logic [15:0]      cmd_mask,
  input  logic [IDX_W-1:0] key_sel,
  output logic             commit_ok,
  output logic [IDX_W-1:0] commit_idx,
  output logic             sel_en,
  output logic             sel_get,
  output logic [31:0]      qres_q
);

  logic [31:0] prot_q [NUM_SLOTS];
  logic [31:0] prot_d [NUM_SLOTS];
  logic [31:0] qres_d;
  logic        in_range;
  logic [31:0] cur;
  logic [31:0] clr_bits;

  assign in_range   = cmd_slot < 16'(NUM_SLOTS);
  assign commit_idx = cmd_slot[IDX_W-1:0];
  assign cur        = in_range ? prot_q[commit_idx] : '0;
  assign commit_ok  = cmd_commit && cur[PB_EXIST] && cur[PB_SETKR];
  assign clr_bits   = {cmd_mask, 16'h0000} & CLEARABLE;

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      prot_d[s] = prot_q[s];
      if (in_range && commit_idx == IDX_W'(s)) begin
        if (commit_ok) prot_d[s][PB_EN] = 1'b1;
        if (cmd_clear) prot_d[s] = prot_q[s] & ~clr_bits;
      end
    end
    qres_d = cmd_query ? cur : qres_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) prot_q[s] <= INIT_PROT[s];
      qres_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) prot_q[s] <= prot_d[s];
      qres_q <= qres_d;
    end
  end

  assign sel_en  = prot_q[key_sel][PB_EN];
  assign sel_get = prot_q[key_sel][PB_GETKR];

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_chk
      assert_fixed_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q[gs][25:21] == INIT_PROT[gs][25:21]);

      assert_enable_needs_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q[gs][PB_EN]) |-> ($past(prot_q[gs][PB_SETKR]) && $past(cmd_commit)));

      assert_absent_stays_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_q[gs][PB_EXIST] |-> (prot_q[gs] == '0));
    end
  endgenerate

  assert_query_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_query |=> $stable(qres_q));

endmodule

// File: rtl/kslot_store.sv
module kslot_store
  import kslot_pkg::*;
#(
  parameter int NUM_SLOTS = DEF_SLOTS,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter int KW        = KEY_W
) (
  input  logic             clk,
  input  logic             commit_ok,
  input  logic [IDX_W-1:0] commit_idx,
  input  logic [KW-1:0]    stage_flat,
  input  logic [IDX_W-1:0] key_sel,
  input  logic             sel_en,
  input  logic             sel_get,
  output logic [KW-1:0]    key_data,
  output logic             key_usable
);

  logic [KW-1:0] mem_q [NUM_SLOTS];
  logic [KW-1:0] mem_d [NUM_SLOTS];

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      mem_d[s] = (commit_ok && commit_idx == IDX_W'(s)) ? stage_flat : mem_q[s];
    end
  end

  // key array carries no reset; reads are masked until a slot is enabled
  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLOTS; s++) mem_q[s] <= mem_d[s];
  end

  assign key_data   = {KW{sel_en & sel_get}} & mem_q[key_sel];
  assign key_usable = sel_en;

endmodule

// File: rtl/kslot_bank.sv
module kslot_bank
  import kslot_pkg::*;
#(
  parameter int NUM_SLOTS = DEF_SLOTS,
  parameter int IDX_W     = $clog2(NUM_SLOTS),
  parameter logic [NUM_SLOTS-1:0][31:0] INIT_PROT = kslot_pkg::default_prot()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_waddr,
  input  logic [31:0]      bus_wdata,
  input  logic [AW-1:0]    bus_raddr,
  output logic [31:0]      bus_rdata,
  input  logic [IDX_W-1:0] key_sel,
  output logic [KEY_W-1:0] key_data,
  output logic             key_usable
);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [KEY_W-1:0] stage_flat;
  logic             cmd_commit, cmd_clear, cmd_query;
  logic [15:0]      cmd_slot, cmd_mask;
  logic [31:0]      qres;
  logic             commit_ok;
  logic [IDX_W-1:0] commit_idx;
  logic             sel_en, sel_get;

  kslot_regif u_regif (
    .clk        (clk),
    .rst_n      (rst_sync),
    .we         (bus_we),
    .waddr      (bus_waddr),
    .wdata      (bus_wdata),
    .raddr      (bus_raddr),
    .qres       (qres),
    .stage_flat (stage_flat),
    .cmd_commit (cmd_commit),
    .cmd_clear  (cmd_clear),
    .cmd_query  (cmd_query),
    .cmd_slot   (cmd_slot),
    .cmd_mask   (cmd_mask),
    .rdata      (bus_rdata)
  );

  kslot_prot #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W),
    .INIT_PROT (INIT_PROT)
  ) u_prot (
    .clk        (clk),
    .rst_n      (rst_sync),
    .cmd_commit (cmd_commit),
    .cmd_clear  (cmd_clear),
    .cmd_query  (cmd_query),
    .cmd_slot   (cmd_slot),
    .cmd_mask   (cmd_mask),
    .key_sel    (key_sel),
    .commit_ok  (commit_ok),
    .commit_idx (commit_idx),
    .sel_en     (sel_en),
    .sel_get    (sel_get),
    .qres_q     (qres)
  );

  kslot_store #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk        (clk),
    .commit_ok  (commit_ok),
    .commit_idx (commit_idx),
    .stage_flat (stage_flat),
    .key_sel    (key_sel),
    .sel_en     (sel_en),
    .sel_get    (sel_get),
    .key_data   (key_data),
    .key_usable (key_usable)
  );

  assert_masked_key_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    !key_usable |-> (key_data == '0));

  assert_blank_regs_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_raddr == RA_COMMIT || bus_raddr == RA_QUERY) |-> (bus_rdata == '0));

endmodule

// File: tb/kslot_bank_tb.sv
`timescale 1ns/1ps
module kslot_bank_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_we;
  logic [3:0]   bus_waddr;
  logic [31:0]  bus_wdata;
  logic [3:0]   bus_raddr;
  logic [31:0]  bus_rdata;
  logic [5:0]   key_sel;
  logic [255:0] key_data;
  logic         key_usable;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  kslot_bank u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_waddr  (bus_waddr),
    .bus_wdata  (bus_wdata),
    .bus_raddr  (bus_raddr),
    .bus_rdata  (bus_rdata),
    .key_sel    (key_sel),
    .key_data   (key_data),
    .key_usable (key_usable)
  );

  // behavioural reference model
  logic [31:0]  m_prot  [64];
  logic [255:0] m_key   [64];
  logic [31:0]  m_stage [8];
  logic [31:0]  m_qres;

  function automatic logic [31:0] init_word(int i);
    logic [31:0] v;
    if (i > 55) return 32'h0;
    v = 32'h1C1F_0001;
    case (1'b1)
      (i < 8):           v = v | 32'h0040_0000;
      (i >= 8 && i < 16): v = v | 32'h0080_0000;
      (i == 16):         v = v | 32'h0060_0000;
      default: ;
    endcase
    if (i >= 40 && i <= 47) v = v & 32'hF7FF_FFFF;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        m_prot[i] = init_word(i);
        m_key[i]  = '0;
      end
      for (int w = 0; w < 8; w++) m_stage[w] = '0;
      m_qres = '0;
    end else if (bus_we) begin
      int s;
      s = int'(bus_wdata[15:0]);
      if (bus_waddr < 8) m_stage[bus_waddr] = bus_wdata;
      else if (bus_waddr == 8) begin
        if (s < 64 && m_prot[s][0] && m_prot[s][27]) begin
          for (int w = 0; w < 8; w++) m_key[s][w*32 +: 32] = m_stage[w];
          m_prot[s][1] = 1'b1;
        end
      end else if (bus_waddr == 9) begin
        if (s < 64)
          for (int b = 16; b < 32; b++)
            if (bus_wdata[b] && !(b >= 21 && b <= 25)) m_prot[s][b] = 1'b0;
      end else if (bus_waddr == 10) begin
        m_qres = (s < 64) ? m_prot[s] : 32'h0;
      end
    end
  end

  function automatic logic [31:0] exp_rdata(logic [3:0] a);
    if (a < 8)   return m_stage[a];
    if (a == 11) return m_qres;
    return 32'h0;
  endfunction

  task automatic cyc(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                     input logic [3:0] ra, input logic [5:0] ks, input string tag);
    logic [255:0] ek;
    logic         eu;
    @(negedge clk);
    bus_we = we; bus_waddr = wa; bus_wdata = wd; bus_raddr = ra; key_sel = ks;
    #1;
    checks++;
    if (bus_rdata !== exp_rdata(ra)) begin
      errors++;
      $display("FAIL %s rdata[%0d] act=%h exp=%h", tag, ra, bus_rdata, exp_rdata(ra));
    end
    eu = m_prot[ks][1];
    ek = (m_prot[ks][1] && m_prot[ks][28]) ? m_key[ks] : '0;
    checks++;
    if (key_data !== ek || key_usable !== eu) begin
      errors++;
      $display("FAIL %s key slot %0d act=%h/%b exp=%h/%b", tag, ks, key_data, key_usable, ek, eu);
    end
  endtask

  logic [31:0] lf = 32'hACE1_2468;
  function automatic logic [31:0] nxt(logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic load_stage(input string tag);
    for (int w = 0; w < 8; w++) begin
      lf = nxt(lf);
      cyc(1'b1, 4'(w), lf, 4'(w), 6'd0, tag);
    end
  endtask

  task automatic commit_and_look(input int s, input string tag);
    cyc(1'b1, 4'd8, 32'(s), 4'd11, 6'(s), tag);
    cyc(1'b1, 4'd10, 32'(s), 4'd11, 6'(s), tag);
    cyc(1'b0, 4'd0, 32'h0, 4'd11, 6'(s), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_waddr = '0; bus_wdata = '0; bus_raddr = '0; key_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) cyc(1'b0, 4'd0, 32'h0, 4'(a), 6'(a), "R1");

    // R8: reset protection table seen through query
    for (int s = 0; s < 64; s++) begin
      cyc(1'b1, 4'd10, 32'(s), 4'd11, 6'(s), "R8");
      cyc(1'b0, 4'd0, 32'h0, 4'd11, 6'(s), "R8");
    end
    // R6: out-of-range query
    cyc(1'b1, 4'd10, 32'h0000_00C8, 4'd11, 6'd0, "R6");
    cyc(1'b0, 4'd0, 32'h0, 4'd11, 6'd0, "R6");

    // R2: staging write and read back
    load_stage("R2");
    for (int w = 0; w < 8; w++) cyc(1'b0, 4'd0, 32'h0, 4'(w), 6'd0, "R2");

    // R3: legal commits
    commit_and_look(3, "R3");
    load_stage("R3"); commit_and_look(9, "R3");
    load_stage("R3"); commit_and_look(16, "R3");
    load_stage("R3"); commit_and_look(33, "R3");
    load_stage("R3"); commit_and_look(55, "R3");

    // R4: blocked commits
    load_stage("R4");
    commit_and_look(41, "R4");
    commit_and_look(58, "R4");
    commit_and_look(63, "R4");
    cyc(1'b1, 4'd8, 32'h0000_0043, 4'd11, 6'd3, "R4");
    cyc(1'b1, 4'd8, 32'hFFFF_0103, 4'd0, 6'd3, "R4");

    // R5: full-mask clear keeps fixed and low bits
    cyc(1'b1, 4'd9, 32'hFFFF_0003, 4'd11, 6'd3, "R5");
    cyc(1'b1, 4'd10, 32'h3, 4'd11, 6'd3, "R5");
    cyc(1'b0, 4'd0, 32'h0, 4'd11, 6'd3, "R5");
    cyc(1'b1, 4'd9, 32'h03E0_0010, 4'd11, 6'd16, "R5");
    cyc(1'b1, 4'd10, 32'h10, 4'd11, 6'd16, "R5");
    cyc(1'b0, 4'd0, 32'h0, 4'd11, 6'd16, "R5");
    // R4: slot 3 lost its write permission
    load_stage("R4");
    commit_and_look(3, "R4");

    // R7: remove only the keyring-read permission
    cyc(1'b0, 4'd0, 32'h0, 4'd0, 6'd9, "R7");
    cyc(1'b1, 4'd9, 32'h1000_0009, 4'd11, 6'd9, "R7");
    cyc(1'b0, 4'd0, 32'h0, 4'd11, 6'd9, "R7");
    commit_and_look(9, "R7");

    // R6: result holds while the slot changes
    cyc(1'b1, 4'd10, 32'd33, 4'd11, 6'd33, "R6");
    cyc(1'b1, 4'd9, 32'hFFFF_0021, 4'd11, 6'd33, "R6");
    cyc(1'b1, 4'd0, 32'h1234_5678, 4'd11, 6'd33, "R6");
    cyc(1'b0, 4'd0, 32'h0, 4'd11, 6'd33, "R6");

    // R9: command addresses and unused space read zero
    for (int a = 8; a < 16; a++) cyc(1'b0, 4'd0, 32'h0, 4'(a), 6'd0, "R9");

    // R3: mixed traffic
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] d;
      lf = nxt(lf); d = lf;
      lf = nxt(lf);
      case (lf[1:0])
        2'd0: cyc(1'b1, {1'b0, d[2:0]}, d, lf[7:4], lf[13:8], "R3");
        2'd1: cyc(1'b1, 4'd8, 32'(d[7:0] % 72), lf[7:4], lf[13:8], "R3");
        2'd2: cyc(1'b1, 4'd9, {d[31:16] & 16'h0101, 10'h0, d[5:0]}, lf[7:4], lf[13:8], "R5");
        default: cyc(1'b1, 4'd10, 32'(d[6:0]), 4'd11, lf[13:8], "R6");
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule